// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It executes a small load/store instruction subset:

- register-register add, subtract, AND, OR and signed set-less-than;
- the immediate forms of those operations;
- word load and word store;
- branch-if-equal;
- an absolute jump.

The core holds the program counter, the next-address selection, a 32-entry general register file, the ALU, the immediate extender and the main decoder. Instruction storage and data storage are two separate word arrays inside the block.

A loader port fills both arrays while reset is held. Once reset is released, the core fetches from byte address zero. Every cycle it shows, at its outputs, the address of the instruction it is executing and that instruction. It also shows the register writeback it will commit at the next rising edge, and any store it will perform at that edge. Those outputs are the only view of the architectural state, and they are what a test environment watches.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0. After reset is released, every general register reads as 0 until it is written.
- R2: Any instruction other than a taken branch or a jump sets the next `pc_o` to the current `pc_o` plus 4. `pc_o` is always a multiple of 4.
- R3: Opcode 0 selects a register-register operation that writes rd (bits 15:11) from rs (bits 25:21) and rt (bits 20:16). The function code in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than. Set-less-than writes 1 when rs < rt as signed values and 0 otherwise.
- R4: Opcodes 8 (add), 10 (set-less-than), 12 (AND) and 13 (OR) combine rs with the 16-bit immediate in bits 15:0, sign-extended, and write rt.
- R5: Opcode 35 loads into rt the data word at byte address rs + sign-extended immediate. The word index is address bits [MEM_AW+1:2].
- R6: Opcode 43 stores rt at byte address rs + sign-extended immediate. The store shows on `st_en_o`, `st_addr_o` and `st_data_o`, writes no register, and is visible to a later load.
- R7: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2; otherwise it is PC+4. The branch writes no register and stores nothing.
- R8: Opcode 2 sets the next PC to bits 31:28 of PC+4, followed by the 26-bit field (bits 25:0) shifted left by 2. The jump writes no register.
- R9: Register 0 reads as 0 at all times. A write aimed at it is dropped, and `wb_en_o` stays low.
- R10: Any other opcode, and any other function code under opcode 0, behaves as a no-operation: no register write, no store, and the next PC is PC+4.
- R11: While `rst_n` is low, a loader write with `ld_en` high fills the instruction array (`ld_dmem`=0) or the data array (`ld_dmem`=1) at word `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 0 instruction array, 1 data array |
| ld_addr | input | MEM_AW | Loader word index |
| ld_data | input | 32 | Loader write word |
| pc_o | output | 32 | Address of the executing instruction |
| instr_o | output | 32 | Executing instruction word |
| wb_en_o | output | 1 | A register write commits at the next edge |
| wb_reg_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | A store commits at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
Nothing is pipelined, so an internal fault reaches the ports either in the same cycle or one cycle later. A wrong decode or ALU result appears at once on the writeback or store outputs of the faulty instruction. A wrong next-PC choice appears on `pc_o` one edge later. A corrupted register stays hidden until an instruction reads it, so the programs store registers back out through `st_data_o` to expose their contents. The programs also cover, as boundary cases, a branch that targets itself, a negative load offset, a store followed by a load from the same word, and writes aimed at register 0.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    NPC_SEQ, NPC_BR, NPC_JMP
  } npc_sel_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    b_imm;
    logic    mem_to_reg;
    logic    mem_write;
    logic    branch;
    logic    jump;
    logic    illegal;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc4,
                                                    input logic [15:0] off);
    logic [XLEN-1:0] ext;
    ext = sext16(off);
    return pc4 + {ext[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc4,
                                                  input logic [25:0] tgt);
    return {pc4[XLEN-1:XLEN-4], tgt, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctl
);
  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctl.reg_write = 1'b1;
        ctl.dst_rd    = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: begin
            ctl.reg_write = 1'b0;
            ctl.illegal   = 1'b1;
          end
        endcase
      end
      OP_ADDI: begin
        ctl.reg_write = 1'b1;
        ctl.b_imm     = 1'b1;
        ctl.alu_op    = ALU_ADD;
      end
      OP_SLTI: begin
        ctl.reg_write = 1'b1;
        ctl.b_imm     = 1'b1;
        ctl.alu_op    = ALU_SLT;
      end
      OP_ANDI: begin
        ctl.reg_write = 1'b1;
        ctl.b_imm     = 1'b1;
        ctl.alu_op    = ALU_AND;
      end
      OP_ORI: begin
        ctl.reg_write = 1'b1;
        ctl.b_imm     = 1'b1;
        ctl.alu_op    = ALU_OR;
      end
      OP_LW: begin
        ctl.reg_write  = 1'b1;
        ctl.b_imm      = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.alu_op     = ALU_ADD;
      end
      OP_SW: begin
        ctl.mem_write = 1'b1;
        ctl.b_imm     = 1'b1;
        ctl.alu_op    = ALU_ADD;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OP_J: begin
        ctl.jump = 1'b1;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int NRP  = 2,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] raddr [NRP],
  output logic [W-1:0]   rdata [NRP],
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [W-1:0]   wdata
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_calc(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/core_wordmem.sv
module core_wordmem #(
  parameter int AW = 6,
  parameter int W  = 32,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import core_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_o,
  output logic [31:0]       instr_o,
  output logic              wb_en_o,
  output logic [4:0]        wb_reg_o,
  output logic [31:0]       wb_data_o,
  output logic              st_en_o,
  output logic [31:0]       st_addr_o,
  output logic [31:0]       st_data_o
);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc4, pc_next, instr;
  logic [XLEN-1:0] imm_ext, alu_b, alu_y, mem_rd, wb_val;
  logic [RAW-1:0]  rf_ra [2];
  logic [XLEN-1:0] rf_rd [2];
  logic [RAW-1:0]  dst;
  ctrl_t           ctl;
  logic            alu_zero, br_taken, is_jump, is_illegal, wb_en;
  logic            dm_we;
  logic [MEM_AW-1:0] dm_waddr;
  logic [XLEN-1:0] dm_wdata;
  npc_sel_e        npc_sel;

  // program counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc4 = pc_q + 32'd4;

  core_wordmem #(.AW(MEM_AW), .W(XLEN)) u_imem (
    .clk   (clk),
    .we    (ld_en & ~ld_dmem),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[MEM_AW+1:2]),
    .rdata (instr)
  );

  core_decode u_decode (
    .instr (instr),
    .ctl   (ctl)
  );

  assign rf_ra[0] = instr[25:21];
  assign rf_ra[1] = instr[20:16];
  assign dst      = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_en    = ctl.reg_write & (dst != '0);

  core_regfile #(.NREG(NREG), .W(XLEN), .NRP(2)) u_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (rf_ra),
    .rdata (rf_rd),
    .we    (wb_en),
    .waddr (dst),
    .wdata (wb_val)
  );

  assign imm_ext = sext16(instr[15:0]);
  assign alu_b   = ctl.b_imm ? imm_ext : rf_rd[1];

  core_alu u_alu (
    .op   (ctl.alu_op),
    .a    (rf_rd[0]),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data array: loader has priority, core stores only out of reset
  always_comb begin
    if (ld_en) begin
      dm_we    = ld_dmem;
      dm_waddr = ld_addr;
      dm_wdata = ld_data;
    end else begin
      dm_we    = rst_n & ctl.mem_write;
      dm_waddr = alu_y[MEM_AW+1:2];
      dm_wdata = rf_rd[1];
    end
  end

  core_wordmem #(.AW(MEM_AW), .W(XLEN)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[MEM_AW+1:2]),
    .rdata (mem_rd)
  );

  assign wb_val = ctl.mem_to_reg ? mem_rd : alu_y;

  // next-PC selection
  assign br_taken   = ctl.branch & alu_zero;
  assign is_jump    = ctl.jump;
  assign is_illegal = ctl.illegal;

  always_comb begin
    if (is_jump)       npc_sel = NPC_JMP;
    else if (br_taken) npc_sel = NPC_BR;
    else               npc_sel = NPC_SEQ;
  end

  always_comb begin
    case (npc_sel)
      NPC_BR:  pc_next = branch_target(pc4, instr[15:0]);
      NPC_JMP: pc_next = jump_target(pc4, instr[25:0]);
      default: pc_next = pc4;
    endcase
  end

  assign pc_o      = pc_q;
  assign instr_o   = instr;
  assign wb_en_o   = wb_en;
  assign wb_reg_o  = dst;
  assign wb_data_o = wb_val;
  assign st_en_o   = ctl.mem_write;
  assign st_addr_o = alu_y;
  assign st_data_o = rf_rd[1];
endmodule

// File: rtl/core_checker.sv
module core_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_o,
  input logic [25:0] jtgt,
  input logic        wb_en_o,
  input logic        st_en_o,
  input logic        br_taken,
  input logic        is_jump,
  input logic        is_illegal
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_pc_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!br_taken && !is_jump)) |-> pc_o == $past(pc_o) + 32'd4);

  assert_jump_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(is_jump)) |-> pc_o[27:0] == {$past(jtgt), 2'b00});

  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_en_o |-> !wb_en_o);

  assert_branch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (!wb_en_o && !st_en_o));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_illegal |-> (!wb_en_o && !st_en_o));
endmodule

bind sc_core core_checker u_core_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_o       (pc_o),
  .jtgt       (instr_o[25:0]),
  .wb_en_o    (wb_en_o),
  .st_en_o    (st_en_o),
  .br_taken   (br_taken),
  .is_jump    (is_jump),
  .is_illegal (is_illegal)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;
  localparam real HALF = 4.0;
  localparam logic [31:0] NOP = 32'hFC00_0000; // opcode 63, unsupported

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic          ld_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   pc_o, instr_o, wb_data_o, st_addr_o, st_data_o;
  logic          wb_en_o, st_en_o;
  logic [4:0]    wb_reg_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] prog [WORDS];
  logic [31:0] dimg [WORDS];

  always #(HALF) clk = ~clk;

  sc_core #(.MEM_AW(AW)) i_sc_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
    .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o),
    .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd,
                                        logic [4:0] rs, logic [4:0] rt);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt,
                                        logic [4:0] rs, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_images();
    for (int i = 0; i < WORDS; i++) begin
      prog[i] = NOP;
      dimg[i] = '0;
    end
  endtask

  // hold reset, fill both arrays, check PC in reset, then release
  task automatic load_and_start();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = AW'(i); ld_data = prog[i];
      @(negedge clk);
      ld_dmem = 1'b1; ld_data = dimg[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    check("R1", "pc in reset", pc_o, 32'd0);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic step_wb(string req, logic [31:0] epc, logic [4:0] ereg, logic [31:0] edata);
    check(req, "pc", pc_o, epc);
    check(req, "wb_en", {31'd0, wb_en_o}, 32'd1);
    check(req, "wb_reg", {27'd0, wb_reg_o}, {27'd0, ereg});
    check(req, "wb_data", wb_data_o, edata);
    check(req, "st_en", {31'd0, st_en_o}, 32'd0);
    @(negedge clk);
  endtask

  task automatic step_st(string req, logic [31:0] epc, logic [31:0] eaddr, logic [31:0] edata);
    check(req, "pc", pc_o, epc);
    check(req, "st_en", {31'd0, st_en_o}, 32'd1);
    check(req, "st_addr", st_addr_o, eaddr);
    check(req, "st_data", st_data_o, edata);
    check(req, "wb_en", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk);
  endtask

  task automatic step_quiet(string req, logic [31:0] epc);
    check(req, "pc", pc_o, epc);
    check(req, "wb_en", {31'd0, wb_en_o}, 32'd0);
    check(req, "st_en", {31'd0, st_en_o}, 32'd0);
    @(negedge clk);
  endtask

  // R3 R4 R2: arithmetic and logic, register and immediate forms
  task automatic t_arith();
    clear_images();
    prog[0]  = enc_i(6'd8, 5'd1, 5'd0, 16'd7);
    prog[1]  = enc_i(6'd8, 5'd2, 5'd0, 16'hFFFD);
    prog[2]  = enc_r(6'h20, 5'd3, 5'd1, 5'd2);
    prog[3]  = enc_r(6'h22, 5'd4, 5'd1, 5'd2);
    prog[4]  = enc_r(6'h24, 5'd5, 5'd1, 5'd2);
    prog[5]  = enc_r(6'h25, 5'd6, 5'd1, 5'd2);
    prog[6]  = enc_r(6'h2A, 5'd7, 5'd2, 5'd1);
    prog[7]  = enc_r(6'h2A, 5'd8, 5'd1, 5'd2);
    prog[8]  = enc_i(6'd10, 5'd9, 5'd2, 16'd0);
    prog[9]  = enc_i(6'd12, 5'd10, 5'd1, 16'h000C);
    prog[10] = enc_i(6'd13, 5'd11, 5'd1, 16'h0010);
    load_and_start();
    step_wb("R4", 32'd0, 5'd1, 32'd7);
    step_wb("R4", 32'd4, 5'd2, 32'hFFFF_FFFD);
    step_wb("R3", 32'd8, 5'd3, 32'd4);
    step_wb("R3", 32'd12, 5'd4, 32'd10);
    step_wb("R3", 32'd16, 5'd5, 32'd5);
    step_wb("R3", 32'd20, 5'd6, 32'hFFFF_FFFF);
    step_wb("R3", 32'd24, 5'd7, 32'd1);
    step_wb("R3", 32'd28, 5'd8, 32'd0);
    step_wb("R4", 32'd32, 5'd9, 32'd1);
    step_wb("R4", 32'd36, 5'd10, 32'd4);
    step_wb("R2", 32'd40, 5'd11, 32'h17);
  endtask

  // R1 R5 R6 R11: loads, stores, preloaded data
  task automatic t_memory();
    clear_images();
    dimg[1] = 32'h0BAD_BEEF;
    dimg[3] = 32'hCAFE_F00D;
    dimg[5] = 32'h1234_5678;
    dimg[7] = 32'h5A5A_0001;
    prog[0] = enc_i(6'd43, 5'd1, 5'd0, 16'd0);
    prog[1] = enc_i(6'd8, 5'd1, 5'd0, 16'd8);
    prog[2] = enc_i(6'd35, 5'd2, 5'd1, 16'd4);
    prog[3] = enc_i(6'd35, 5'd3, 5'd1, 16'hFFFC);
    prog[4] = enc_i(6'd43, 5'd2, 5'd1, 16'd12);
    prog[5] = enc_i(6'd35, 5'd4, 5'd0, 16'd20);
    prog[6] = enc_i(6'd35, 5'd5, 5'd0, 16'd28);
    load_and_start();
    step_st("R1", 32'd0, 32'd0, 32'd0);
    step_wb("R4", 32'd4, 5'd1, 32'd8);
    step_wb("R5", 32'd8, 5'd2, 32'hCAFE_F00D);
    step_wb("R5", 32'd12, 5'd3, 32'h0BAD_BEEF);
    step_st("R6", 32'd16, 32'd20, 32'hCAFE_F00D);
    step_wb("R6", 32'd20, 5'd4, 32'hCAFE_F00D);
    step_wb("R11", 32'd24, 5'd5, 32'h5A5A_0001);
  endtask

  // R7 R8: taken, not-taken, jump, self-loop
  task automatic t_flow();
    clear_images();
    prog[0]  = enc_i(6'd8, 5'd1, 5'd0, 16'd5);
    prog[1]  = enc_i(6'd8, 5'd2, 5'd0, 16'd5);
    prog[2]  = enc_i(6'd4, 5'd2, 5'd1, 16'd2);
    prog[3]  = enc_i(6'd8, 5'd3, 5'd0, 16'd1);
    prog[4]  = enc_i(6'd8, 5'd3, 5'd0, 16'd2);
    prog[5]  = enc_i(6'd4, 5'd0, 5'd1, 16'd5);
    prog[6]  = enc_j(26'd16);
    prog[16] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);
    load_and_start();
    step_wb("R4", 32'd0, 5'd1, 32'd5);
    step_wb("R4", 32'd4, 5'd2, 32'd5);
    step_quiet("R7", 32'd8);
    step_quiet("R7", 32'd20);
    step_quiet("R8", 32'd24);
    step_quiet("R7", 32'd64);
    step_quiet("R7", 32'd64);
  endtask

  // R9 R10: register zero and unsupported encodings
  task automatic t_zero_and_illegal();
    clear_images();
    prog[0] = enc_i(6'd8, 5'd1, 5'd0, 16'd9);
    prog[1] = enc_i(6'd8, 5'd0, 5'd1, 16'd5);
    prog[2] = enc_i(6'd43, 5'd0, 5'd0, 16'd4);
    prog[3] = NOP;
    prog[4] = enc_r(6'h3F, 5'd3, 5'd1, 5'd1);
    prog[5] = enc_i(6'd43, 5'd3, 5'd0, 16'd8);
    prog[6] = enc_i(6'd15, 5'd4, 5'd1, 16'd1);
    prog[7] = enc_i(6'd43, 5'd4, 5'd0, 16'd12);
    load_and_start();
    step_wb("R4", 32'd0, 5'd1, 32'd9);
    step_quiet("R9", 32'd4);
    step_st("R9", 32'd8, 32'd4, 32'd0);
    step_quiet("R10", 32'd12);
    step_quiet("R10", 32'd16);
    step_st("R10", 32'd20, 32'd8, 32'd0);
    step_quiet("R10", 32'd24);
    step_st("R10", 32'd28, 32'd12, 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(HALF * 2.0 * 150000.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_arith();
    t_memory();
    t_flow();
    t_zero_and_illegal();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule